// File: doc/BRIEF.md
# UART Status and Interrupt Flag Register

This block holds the status flags of a UART receive/transmit pair and raises the UART's single interrupt line. One-cycle event pulses from the receiver, the transmitter and the pin logic are turned into sticky flags. Software clears a sticky flag by writing a 1 to its bit. Three further flags are level flags: transmit FIFO empty, transmit complete and receive data ready. They follow the FIFO and shifter state and clear on data-path actions. Software writes to them are ignored.

The RTS pin is asynchronous. It passes through a synchronizer before its edge detector, and a select field chooses which edge sets the RTS flag. A one-bit register bus reaches two words: the flag word at address 0 and the interrupt enable word at address 1. The interrupt output is registered. It is high one cycle after any flag is set whose enable bit is also set.

Top module: `uart_stat_flags`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the flag word, the enable word and `irq_o` all read 0.
- R2: A pulse on a sticky event input sets its flag at the next clock edge. The flag then holds until a 1 is written to that bit at address 0. Writing 0 to that bit leaves the flag unchanged.
- R3: A write to address 0 clears exactly those sticky flags whose data bit is 1. It has no effect on the level flags (bits 14, 3 and 0).
- R4: If a set event and a write-1 clear reach the same sticky flag in the same cycle, the flag ends up set.
- R5: The overrun flag (bit 1) sets when `rx_done_i` pulses while `rx_full_i` is high. That character is not counted as a push, so it does not set the ready flag.
- R6: The ready flag (bit 0) sets one cycle after a push (`rx_done_i` while not full). It clears only after a `rx_pop_i` with `rx_cnt_i` equal to 1 and no push in the same cycle. A pop with a count above 1 leaves it set.
- R7: The TX-FIFO-empty flag (bit 14) is the transmit FIFO empty input, delayed by one register. It reads 0 in the cycle after a `tx_wr_i` pulse, whatever that input shows, and it can be 1 while the shifter is still busy.
- R8: The TX-complete flag (bit 3) is 1 one cycle after a cycle with no `tx_wr_i` in which both the FIFO and the shifter report empty. Otherwise it is 0.
- R9: RTS passes through two synchronizing flops. The flag (bit 4) sets on the third clock edge after the pin changes. The edge is chosen by `rts_sel_i`: 00 selects rising, 01 selects falling, and 1x selects both.
- R10: `irq_o` is the OR of (flag AND enable) over all 16 bits, registered by one cycle. The enable word is written and read at address 1.
- R11: The flag word places its bits as follows: bit 15 autobaud done, 14 TX FIFO empty, 12 idle, 11 autobaud counter stopped, 8 IR edge, 7 start-bit wake, 5 RXD falling-edge wake, 4 RTS edge, 3 TX complete, 2 break, 1 overrun, 0 ready. Bits 13, 10, 9 and 6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ev_start_i | input | 1 | Start bit seen pulse |
| ev_rxd_fall_i | input | 1 | RXD falling edge pulse |
| ev_brk_i | input | 1 | Break detected pulse |
| ev_idle_i | input | 1 | Receive idle pulse |
| ev_ir_i | input | 1 | Infrared edge pulse |
| ev_abd_done_i | input | 1 | Autobaud complete pulse |
| ev_abd_stop_i | input | 1 | Autobaud counter stopped pulse |
| rx_done_i | input | 1 | A character finished reception |
| rx_full_i | input | 1 | Receive FIFO is full |
| rx_pop_i | input | 1 | Receive data register read |
| rx_cnt_i | input | RX_CNT_W | Receive FIFO occupancy |
| tx_wr_i | input | 1 | Word written into the transmit FIFO |
| tx_fifo_empty_i | input | 1 | Transmit FIFO empty |
| tx_shift_empty_i | input | 1 | Transmit shifter idle |
| rts_i | input | 1 | Asynchronous RTS pin |
| rts_sel_i | input | 2 | RTS edge select |
| bus_addr_i | input | 1 | 0 flag word, 1 enable word |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the addressed word |
| irq_o | output | 1 | Registered interrupt |

## Verification
The case hardest to reach from the ports is a set and a clear landing on the same flag in the same cycle. It needs a bus write and an event pulse timed to the same edge. The bench drives both inputs from one negative edge for every sticky bit in turn. The RTS path is swept over all four select codes in both edge directions, and the bench samples the flag both one edge before and at the third edge after each pin change, which pins down the synchronizer latency. The ready flag is driven through a pop with a count above one and a pop that coincides with a push, so that only a genuine last-entry read clears it.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int unsigned STAT_W   = 16;
  localparam int unsigned B_RDY    = 0;
  localparam int unsigned B_OVR    = 1;
  localparam int unsigned B_BRK    = 2;
  localparam int unsigned B_TXDC   = 3;
  localparam int unsigned B_RTS    = 4;
  localparam int unsigned B_RXFALL = 5;
  localparam int unsigned B_WAKE   = 7;
  localparam int unsigned B_IR     = 8;
  localparam int unsigned B_ABSTOP = 11;
  localparam int unsigned B_IDLE   = 12;
  localparam int unsigned B_TXFE   = 14;
  localparam int unsigned B_ABDONE = 15;

  localparam logic [STAT_W-1:0] STICKY_MASK =
      (STAT_W'(1) << B_OVR)    | (STAT_W'(1) << B_BRK)  |
      (STAT_W'(1) << B_RTS)    | (STAT_W'(1) << B_RXFALL) |
      (STAT_W'(1) << B_WAKE)   | (STAT_W'(1) << B_IR)   |
      (STAT_W'(1) << B_ABSTOP) | (STAT_W'(1) << B_IDLE) |
      (STAT_W'(1) << B_ABDONE);
endpackage

// File: rtl/usf_rts_edge.sv
module usf_rts_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] sel_i,
  output logic       edge_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;
  logic              rise, fall;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;

  always_comb begin
    if (sel_i[1])      edge_o = rise | fall;
    else if (sel_i[0]) edge_o = fall;
    else               edge_o = rise;
  end

  // R9: never reports an edge while the synchronized level is stable
  p_stable_no_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q[STAGES-1] == prev_q) |-> !edge_o);
endmodule

// File: rtl/usf_sticky_bank.sv
module usf_sticky_bank #(
  parameter int unsigned     W    = 16,
  parameter logic [W-1:0]    MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_flag
      logic q, d, en;
      always_comb begin
        en = set_i[i] | clr_i[i];
        d  = set_i[i];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= 1'b0;
        else if (en)  q <= d;
      end
      assign q_o[i] = q;

      p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[i] |=> q_o[i]);
      p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_o[i] && !clr_i[i]) |=> q_o[i]);
      p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[i] && !set_i[i]) |=> !q_o[i]);
    end else begin : g_none
      logic unused_in;
      assign unused_in = set_i[i] ^ clr_i[i];
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/usf_level_flags.sv
module usf_level_flags #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_wr_i,
  input  logic             tx_fifo_empty_i,
  input  logic             tx_shift_empty_i,
  input  logic             rx_push_i,
  input  logic             rx_pop_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  output logic             txfe_o,
  output logic             txdc_o,
  output logic             rdy_o
);
  logic txfe_q, txfe_d, txdc_q, txdc_d, rdy_q, rdy_d;
  logic last_pop;

  assign last_pop = rx_pop_i && (rx_cnt_i == CNT_W'(1));

  always_comb begin
    txfe_d = tx_fifo_empty_i & ~tx_wr_i;
    txdc_d = tx_fifo_empty_i & tx_shift_empty_i & ~tx_wr_i;
    if (rx_push_i)     rdy_d = 1'b1;
    else if (last_pop) rdy_d = 1'b0;
    else               rdy_d = rdy_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txfe_q <= 1'b0;
      txdc_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      txfe_q <= txfe_d;
      txdc_q <= txdc_d;
      rdy_q  <= rdy_d;
    end
  end

  assign txfe_o = txfe_q;
  assign txdc_o = txdc_q;
  assign rdy_o  = rdy_q;

  p_txfe_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i |=> !txfe_o);
  p_txdc_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i |=> !txdc_o);
  p_txdc_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_shift_empty_i |=> !txdc_o);
  p_rdy_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_pop && !rx_push_i) |=> !rdy_o);
  p_rdy_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && !last_pop) |=> rdy_o);
endmodule

// File: rtl/uart_stat_flags.sv
module uart_stat_flags
  import uart_stat_pkg::*;
#(
  parameter int unsigned RX_CNT_W    = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ev_start_i,
  input  logic                ev_rxd_fall_i,
  input  logic                ev_brk_i,
  input  logic                ev_idle_i,
  input  logic                ev_ir_i,
  input  logic                ev_abd_done_i,
  input  logic                ev_abd_stop_i,
  input  logic                rx_done_i,
  input  logic                rx_full_i,
  input  logic                rx_pop_i,
  input  logic [RX_CNT_W-1:0] rx_cnt_i,
  input  logic                tx_wr_i,
  input  logic                tx_fifo_empty_i,
  input  logic                tx_shift_empty_i,
  input  logic                rts_i,
  input  logic [1:0]          rts_sel_i,
  input  logic                bus_addr_i,
  input  logic                bus_wr_i,
  input  logic [15:0]         bus_wdata_i,
  output logic [15:0]         bus_rdata_o,
  output logic                irq_o
);
  logic [STAT_W-1:0] set_vec, clr_vec, sticky, flags;
  logic [STAT_W-1:0] en_q, en_d;
  logic              en_we, irq_q, irq_d;
  logic              rts_edge, rx_push, rx_ovr;
  logic              txfe, txdc, rdy;

  assign rx_push = rx_done_i & ~rx_full_i;
  assign rx_ovr  = rx_done_i &  rx_full_i;

  usf_rts_edge #(.STAGES(SYNC_STAGES)) u_rts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (rts_i),
    .sel_i (rts_sel_i),
    .edge_o(rts_edge)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[B_OVR]    = rx_ovr;
    set_vec[B_BRK]    = ev_brk_i;
    set_vec[B_RTS]    = rts_edge;
    set_vec[B_RXFALL] = ev_rxd_fall_i;
    set_vec[B_WAKE]   = ev_start_i;
    set_vec[B_IR]     = ev_ir_i;
    set_vec[B_ABSTOP] = ev_abd_stop_i;
    set_vec[B_IDLE]   = ev_idle_i;
    set_vec[B_ABDONE] = ev_abd_done_i;
    clr_vec = (bus_wr_i && !bus_addr_i) ? (bus_wdata_i & STICKY_MASK) : '0;
  end

  usf_sticky_bank #(.W(STAT_W), .MASK(STICKY_MASK)) u_sticky (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .q_o   (sticky)
  );

  usf_level_flags #(.CNT_W(RX_CNT_W)) u_level (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .tx_wr_i         (tx_wr_i),
    .tx_fifo_empty_i (tx_fifo_empty_i),
    .tx_shift_empty_i(tx_shift_empty_i),
    .rx_push_i       (rx_push),
    .rx_pop_i        (rx_pop_i),
    .rx_cnt_i        (rx_cnt_i),
    .txfe_o          (txfe),
    .txdc_o          (txdc),
    .rdy_o           (rdy)
  );

  always_comb begin
    flags         = sticky;
    flags[B_TXFE] = txfe;
    flags[B_TXDC] = txdc;
    flags[B_RDY]  = rdy;
  end

  always_comb begin
    en_we = bus_wr_i & bus_addr_i;
    en_d  = bus_wdata_i;
    irq_d = |(flags & en_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (en_we) en_q <= en_d;
      irq_q <= irq_d;
    end
  end

  assign bus_rdata_o = bus_addr_i ? en_q : flags;
  assign irq_o       = irq_q;

  p_irq_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flags & en_q)) |=> irq_o);
  p_irq_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |=> !irq_o);
  p_ovr_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && rx_full_i) |=> flags[B_OVR]);
  p_unused_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags[13] == 1'b0) && (flags[10] == 1'b0) && (flags[9] == 1'b0) && (flags[6] == 1'b0));
endmodule

// File: tb/uart_stat_flags_test.sv
module uart_stat_flags_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  evv;
  logic        push_b, full_b, pop_b, twr, tfe, tsh, rts, baddr, bwr;
  logic [4:0]  cnt_b;
  logic [1:0]  rsel;
  logic [15:0] wdata, rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  uart_stat_flags uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ev_start_i(evv[4]), .ev_rxd_fall_i(evv[5]), .ev_brk_i(evv[6]),
    .ev_idle_i(evv[1]), .ev_ir_i(evv[3]), .ev_abd_done_i(evv[0]),
    .ev_abd_stop_i(evv[2]),
    .rx_done_i(evv[7] | push_b), .rx_full_i(evv[7] | full_b),
    .rx_pop_i(pop_b), .rx_cnt_i(cnt_b),
    .tx_wr_i(twr), .tx_fifo_empty_i(tfe), .tx_shift_empty_i(tsh),
    .rts_i(rts), .rts_sel_i(rsel),
    .bus_addr_i(baddr), .bus_wr_i(bwr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  // bit of the flag word set by each bench event index
  int pos [8] = '{15, 12, 11, 8, 7, 5, 2, 1};

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [15:0] d);
    baddr = a; bwr = 1'b1; wdata = d;
    step();
    bwr = 1'b0; baddr = 1'b0; wdata = '0;
  endtask

  task automatic pulse(int k);
    evv = 8'(1 << k);
    step();
    evv = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evv = '0; push_b = 0; full_b = 0; pop_b = 0; cnt_b = '0;
    twr = 0; tfe = 0; tsh = 0; rts = 0; rsel = 2'b00; baddr = 0; bwr = 0; wdata = '0;
    repeat (3) step();
    chk("R1 flags in reset", rdata, 16'h0000);
    chk("R1 irq in reset", {15'd0, irq}, 16'h0000);
    rst_n = 1'b1;
    step();
    chk("R1 flags after reset", rdata, 16'h0000);
    baddr = 1'b1; #1;
    chk("R1 enable after reset", rdata, 16'h0000);
    baddr = 1'b0;

    // R11: writing all ones to an empty word reads back zero
    wr(1'b0, 16'hFFFF);
    chk("R11 unused bits", rdata, 16'h0000);

    // sticky sweep: R2, R3, R4, R5, R11
    for (int k = 0; k < 8; k++) begin
      logic [15:0] b;
      b = 16'(1 << pos[k]);
      pulse(k);
      chk("R2 set at position", rdata, b);
      wr(1'b0, ~b);
      chk("R2 write 0 keeps", rdata, b);
      wr(1'b0, b);
      chk("R3 write 1 clears", rdata, 16'h0000);
      evv = 8'(1 << k); baddr = 0; bwr = 1; wdata = b;
      step();
      evv = '0; bwr = 0; wdata = '0;
      chk("R4 set beats clear", rdata, b);
      wr(1'b0, b);
      chk("R3 cleared again", rdata, 16'h0000);
    end
    chk("R5 overrun did not set ready", rdata & 16'h0001, 16'h0000);

    // interrupt sweep: R10
    for (int k = 0; k < 8; k++) begin
      logic [15:0] b;
      b = 16'(1 << pos[k]);
      wr(1'b1, ~b);
      baddr = 1'b1; #1;
      chk("R10 enable readback", rdata, ~b);
      baddr = 1'b0;
      pulse(k);
      step();
      chk("R10 masked flag", {15'd0, irq}, 16'h0000);
      wr(1'b1, b);
      chk("R10 irq registered", {15'd0, irq}, 16'h0000);
      step();
      chk("R10 irq raised", {15'd0, irq}, 16'h0001);
      wr(1'b0, b);
      step();
      chk("R10 irq dropped", {15'd0, irq}, 16'h0000);
      wr(1'b1, 16'h0000);
    end

    // RTS edge select sweep: R9
    for (int s = 0; s < 4; s++) begin
      logic [15:0] er, ef;
      rsel = 2'(s);
      er = (s != 1) ? 16'h0010 : 16'h0000;
      ef = (s != 0) ? 16'h0010 : 16'h0000;
      rts = 1'b1;
      step(); step();
      chk("R9 sync latency rise", rdata, 16'h0000);
      step();
      chk("R9 rising edge", rdata, er);
      wr(1'b0, 16'h0010);
      rts = 1'b0;
      step(); step();
      chk("R9 sync latency fall", rdata, 16'h0000);
      step();
      chk("R9 falling edge", rdata, ef);
      wr(1'b0, 16'h0010);
    end
    rsel = 2'b00;

    // transmit level flags: R7, R8, R3
    tfe = 1'b1;
    step();
    chk("R7 empty while shifting", rdata, 16'h4000);
    tsh = 1'b1;
    step();
    chk("R8 complete when both empty", rdata, 16'h4008);
    wr(1'b0, 16'hFFFF);
    chk("R3 level bits ignore write", rdata, 16'h4008);
    twr = 1'b1;
    step();
    twr = 1'b0;
    chk("R7 R8 write clears", rdata, 16'h0000);
    step();
    chk("R8 returns when empty", rdata, 16'h4008);
    tfe = 1'b0; tsh = 1'b0;
    step();
    chk("R7 follows fifo", rdata, 16'h0000);

    // receive ready: R6
    push_b = 1'b1; cnt_b = 5'd0;
    step();
    push_b = 1'b0; cnt_b = 5'd1;
    chk("R6 set on push", rdata, 16'h0001);
    wr(1'b0, 16'h0001);
    chk("R3 ready ignores write", rdata, 16'h0001);
    pop_b = 1'b1; push_b = 1'b1;
    step();
    pop_b = 1'b0; push_b = 1'b0;
    chk("R6 pop with push keeps", rdata, 16'h0001);
    cnt_b = 5'd2; pop_b = 1'b1;
    step();
    pop_b = 1'b0; cnt_b = 5'd1;
    chk("R6 pop of two keeps", rdata, 16'h0001);
    pop_b = 1'b1;
    step();
    pop_b = 1'b0; cnt_b = 5'd0;
    chk("R6 last pop clears", rdata, 16'h0000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule